// File: doc/BRIEF.md
# Antiphase Constant-Width Pulse Generator

This block drives two single-bit pulse lines at one shared, programmable repetition rate. The second line fires exactly half a repetition interval after the first. Both pulses keep the same fixed high time, whatever the interval. The timing comes from a triangle counter. It climbs from zero to a programmed peak value and then falls back to zero. Line A starts high at the bottom of the triangle. Line B starts high at the top. Each stays high for the programmed width.

Software writes two values through a simple write port: the peak count and the pulse width. Both writes land in holding registers. The working copies change only at the bottom of the triangle. At that point the fall threshold for line B is derived from the held peak and the held width, so the pair always takes effect together. Because of this, a change of rate never shortens or stretches a pulse that is already running.

Two one-clock strobes mark the bottom and the top of the triangle. Either strobe can pace the software that supplies new values. A held configuration that cannot produce two separated pulses is refused. In that case the outputs stay low and a sticky error flag is raised.

Top module: `antiphase_pulse_gen`

## Requirements
- R1: With an active peak count P, the counter visits 0, 1, …, P, P-1, …, 1 and repeats. Bottom strobes are therefore 2P clocks apart, and the count never exceeds P.
- R2: `pulse_a` goes high in the same cycle as `zero_evt` and stays high for exactly W cycles, where W is the active width.
- R3: `pulse_b` goes high exactly P cycles after `pulse_a` rises, in the same cycle as `prd_evt`. It stays high for exactly W cycles, and the two lines are never high together.
- R4: `zero_evt` and `prd_evt` are each high for exactly one clock per triangle.
- R5: A write takes effect only at the next bottom of the triangle. The triangle in progress keeps its old length and widths.
- R6: A write sampled on the same clock edge at which the counter sits at zero stays in the holding register. It takes effect only at the following bottom, one full triangle later.
- R7: A held configuration is invalid when W = 0 or P ≤ W. If such a configuration is present at the bottom, it is not loaded: both outputs stay low for that triangle, the previous peak keeps the triangle length, and `cfg_err` goes high and stays high until reset.
- R8: During reset, `pulse_a`, `pulse_b`, `zero_evt`, `prd_evt` and `cfg_err` are low. The first `zero_evt` comes one clock after reset is released, and the first triangle uses the reset defaults `RST_PERIOD` and `RST_WIDTH`.
- R9: Write selection: when `wr_en` is high, `wr_sel` = 0 writes `wr_data` to the held peak count, and `wr_sel` = 1 writes it to the held width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the holding registers |
| wr_sel | input | 1 | 0 = peak count, 1 = pulse width |
| wr_data | input | CNT_W | Value to write |
| pulse_a | output | 1 | Pulse line starting at the triangle bottom |
| pulse_b | output | 1 | Pulse line starting at the triangle top |
| zero_evt | output | 1 | One-clock strobe at the bottom, aligned with the rise of `pulse_a` |
| prd_evt | output | 1 | One-clock strobe at the top, aligned with the rise of `pulse_b` |
| cfg_err | output | 1 | Sticky flag: an invalid configuration was refused |

## Verification
The assertions check these rules on every clock:
- the count stays within the peak, and the direction turns at the peak;
- the working registers stay still away from the bottom;
- each strobe lasts a single cycle;
- each pulse rises only together with its strobe;
- the two lines never overlap;
- the outputs stay low while a configuration is refused;
- the error flag never clears on its own.

Only the bench scenarios can show the actual cycle counts: the 2P triangle length, the W-cycle high times and the P-cycle spacing across a chain of rate changes. The same holds for the one-triangle deferral of a write that hits the bottom edge, and for the recovery timing after a refused configuration and after reset.

// File: rtl/apg_pkg.sv
// Shared types for the antiphase pulse generator.
package apg_pkg;
    // Target of a write on the configuration port.
    typedef enum logic {
        SEL_PERIOD = 1'b0,
        SEL_WIDTH  = 1'b1
    } wsel_e;
endpackage

// File: rtl/apg_timebase.sv
// Up-down time-base counter.
// Counts 0..prd_act and back down to 1, then returns to 0.
// Assumes prd_act only changes on the edge that leaves count 0.
module apg_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] prd_act,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_up,
    output logic             at_zero,
    output logic             at_peak
);
    // Decode the bottom and the top of the triangle.
    always_comb begin
        at_zero = (cnt == '0);
        at_peak = cnt_up && (cnt >= prd_act);
    end

    // Step the counter and turn its direction at either end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            cnt_up <= 1'b1;
        end else if (at_zero) begin
            cnt    <= CNT_W'(1);
            cnt_up <= 1'b1;
        end else if (at_peak) begin
            cnt    <= cnt - 1'b1;
            cnt_up <= 1'b0;
        end else if (cnt_up) begin
            cnt    <= cnt + 1'b1;
        end else begin
            cnt    <= cnt - 1'b1;
        end
    end

    // R1: the count never passes the active peak.
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= prd_act);
    // R1: reaching the peak while rising turns the counter downward.
    p_turn_at_peak_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_up && cnt == prd_act) |=> !cnt_up);
endmodule

// File: rtl/apg_shadow.sv
// Holding and working registers for the peak count and the width.
// Writes go to the holding copies. At the bottom of the triangle a valid
// pair is copied into the working set, and the B threshold is derived
// there as peak minus width. An invalid pair is refused: the outputs are
// held low and a sticky error is raised.
module apg_shadow #(
    parameter int CNT_W      = 16,
    parameter int RST_PERIOD = 30000,
    parameter int RST_WIDTH  = 180
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  apg_pkg::wsel_e   wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             at_zero,
    output logic [CNT_W-1:0] prd_act,
    output logic [CNT_W-1:0] cmpa_act,
    output logic [CNT_W-1:0] cmpb_act,
    output logic             load_ok,
    output logic             hold,
    output logic             cfg_err
);
    localparam logic [CNT_W-1:0] P0 = CNT_W'(RST_PERIOD);
    localparam logic [CNT_W-1:0] W0 = CNT_W'(RST_WIDTH);

    logic [CNT_W-1:0] prd_sh;
    logic [CNT_W-1:0] wid_sh;

    // R7: the held pair is usable only if the two pulses stay separate.
    always_comb load_ok = (wid_sh != '0) && (prd_sh > wid_sh);

    // R9: steer a write into the selected holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_sh <= P0;
            wid_sh <= W0;
        end else if (wr_en) begin
            if (wr_sel == apg_pkg::SEL_PERIOD) prd_sh <= wr_data;
            else                               wid_sh <= wr_data;
        end
    end

    // R5/R6/R7: copy the held pair into the working set at the bottom, or refuse it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_act  <= P0;
            cmpa_act <= W0;
            cmpb_act <= P0 - W0;
            hold     <= 1'b0;
            cfg_err  <= 1'b0;
        end else if (at_zero) begin
            if (load_ok) begin
                prd_act  <= prd_sh;
                cmpa_act <= wid_sh;
                cmpb_act <= prd_sh - wid_sh;
                hold     <= 1'b0;
            end else begin
                hold     <= 1'b1;
                cfg_err  <= 1'b1;
            end
        end
    end

    // R5: the working set is stable on every edge away from the bottom.
    p_active_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !at_zero |=> ($stable(prd_act) && $stable(cmpa_act) && $stable(cmpb_act)));
    // R7: once raised, the error flag stays raised.
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
endmodule

// File: rtl/apg_action.sv
// Output action registers. Line A is set at the bottom and cleared when the
// rising count meets the A threshold. Line B is set at the top and cleared
// when the falling count meets the B threshold. The strobes are registered
// so that each one lines up with the rise of its pulse.
module apg_action #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_up,
    input  logic             at_zero,
    input  logic             at_peak,
    input  logic [CNT_W-1:0] cmpa_act,
    input  logic [CNT_W-1:0] cmpb_act,
    input  logic             load_ok,
    input  logic             hold,
    output logic             pulse_a,
    output logic             pulse_b,
    output logic             zero_evt,
    output logic             prd_evt
);
    // R2: drive line A from the bottom event and the A threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pulse_a <= 1'b0;
        else if (at_zero)                    pulse_a <= load_ok;
        else if (cnt_up && cnt == cmpa_act)  pulse_a <= 1'b0;
    end

    // R3: drive line B from the top event and the B threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pulse_b <= 1'b0;
        else if (at_peak)                    pulse_b <= !hold;
        else if (!cnt_up && cnt == cmpb_act) pulse_b <= 1'b0;
    end

    // R4: register the one-clock triangle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_evt <= 1'b0;
            prd_evt  <= 1'b0;
        end else begin
            zero_evt <= at_zero;
            prd_evt  <= at_peak;
        end
    end

    // R4: each strobe lasts a single clock.
    p_zero_one_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> !zero_evt);
    p_prd_one_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prd_evt |=> !prd_evt);
    // R2: line A rises only together with the bottom strobe.
    p_a_rise_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_a) |-> zero_evt);
    // R3: line B rises only together with the top strobe, and never overlaps A.
    p_b_rise_peak_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_b) |-> prd_evt);
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(pulse_a && pulse_b));
endmodule

// File: rtl/antiphase_pulse_gen.sv
// Top level of the antiphase constant-width pulse generator.
// Ties the time base, the holding/working registers and the output actions
// together. Assumes a single clock domain and a synchronous active-low reset.
module antiphase_pulse_gen #(
    parameter int CNT_W      = 16,
    parameter int RST_PERIOD = 30000,
    parameter int RST_WIDTH  = 180
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pulse_a,
    output logic             pulse_b,
    output logic             zero_evt,
    output logic             prd_evt,
    output logic             cfg_err
);
    logic [CNT_W-1:0] cnt;
    logic             cnt_up;
    logic             at_zero;
    logic             at_peak;
    logic [CNT_W-1:0] prd_act;
    logic [CNT_W-1:0] cmpa_act;
    logic [CNT_W-1:0] cmpb_act;
    logic             load_ok;
    logic             hold;
    apg_pkg::wsel_e   sel_typed;

    // Give the raw select bit its typed meaning.
    always_comb sel_typed = apg_pkg::wsel_e'(wr_sel);

    apg_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .prd_act(prd_act),
        .cnt(cnt), .cnt_up(cnt_up), .at_zero(at_zero), .at_peak(at_peak)
    );

    apg_shadow #(.CNT_W(CNT_W), .RST_PERIOD(RST_PERIOD), .RST_WIDTH(RST_WIDTH)) u_sh (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(sel_typed),
        .wr_data(wr_data), .at_zero(at_zero), .prd_act(prd_act),
        .cmpa_act(cmpa_act), .cmpb_act(cmpb_act), .load_ok(load_ok),
        .hold(hold), .cfg_err(cfg_err)
    );

    apg_action #(.CNT_W(CNT_W)) u_act (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_up(cnt_up),
        .at_zero(at_zero), .at_peak(at_peak), .cmpa_act(cmpa_act),
        .cmpb_act(cmpb_act), .load_ok(load_ok), .hold(hold),
        .pulse_a(pulse_a), .pulse_b(pulse_b), .zero_evt(zero_evt),
        .prd_evt(prd_evt)
    );

    // R7: a refused configuration keeps both lines low.
    p_hold_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (!pulse_a && !pulse_b));
endmodule

// File: tb/tb_antiphase_pulse_gen.sv
`timescale 1ns/1ps
// Self-checking bench. A vector table of peak/width pairs is chained through
// one loop, then directed tests cover the zero-edge write, refused
// configurations and reset.
module tb_antiphase_pulse_gen;
    localparam int CW = 16;
    localparam int RP = 20;
    localparam int RW = 3;
    localparam int NV = 6;
    localparam int VP[NV] = '{20, 8, 50, 4, 33, 12};
    localparam int VW[NV] = '{3,  3, 7,  3, 1,  6};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [CW-1:0] wr_data = '0;
    logic pulse_a, pulse_b, zero_evt, prd_evt, cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    int a_hi, a_off, b_off, b_hi, len, prd_off, prd_n;

    always #4 clk = ~clk;

    antiphase_pulse_gen #(.CNT_W(CW), .RST_PERIOD(RP), .RST_WIDTH(RW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pulse_a(pulse_a), .pulse_b(pulse_b),
        .zero_evt(zero_evt), .prd_evt(prd_evt), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Walk one triangle from a negedge where zero_evt is high to the next
    // one. Optionally write peak (offset 1) and width (offset 2).
    task automatic measure(input bit do_wr, input int wp, input int ww);
        a_hi = 0; b_hi = 0; a_off = -1; b_off = -1;
        prd_off = -1; prd_n = 0; len = 0;
        for (int i = 0; i < 100000; i++) begin
            if (i > 0 && zero_evt) begin
                len = i;
                break;
            end
            if (pulse_a) begin a_hi++; if (a_off < 0) a_off = i; end
            if (pulse_b) begin b_hi++; if (b_off < 0) b_off = i; end
            if (prd_evt) begin prd_n++; if (prd_off < 0) prd_off = i; end
            if (do_wr) begin
                if (i == 1) begin wr_en = 1'b1; wr_sel = 1'b0; wr_data = CW'(wp); end
                if (i == 2) begin wr_en = 1'b1; wr_sel = 1'b1; wr_data = CW'(ww); end
                if (i == 3) wr_en = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    task automatic expect_tri(input string tag, input int p, input int w);
        chk({tag, " R1 triangle length"}, len, 2 * p);
        chk({tag, " R2 A starts with zero strobe"}, a_off, 0);
        chk({tag, " R2 A high time"}, a_hi, w);
        chk({tag, " R3 B rise offset"}, b_off, p);
        chk({tag, " R3 B high time"}, b_hi, w);
        chk({tag, " R3 top strobe offset"}, prd_off, p);
        chk({tag, " R4 top strobe count"}, prd_n, 1);
    endtask

    task automatic expect_held(input string tag, input int p);
        chk({tag, " R7 triangle length"}, len, 2 * p);
        chk({tag, " R7 A held low"}, a_hi, 0);
        chk({tag, " R7 B held low"}, b_hi, 0);
        chk({tag, " R4 top strobe count"}, prd_n, 1);
        chk({tag, " R7 error flag"}, int'(cfg_err), 1);
    endtask

    task automatic check_reset_outputs(input string tag);
        chk({tag, " R8 pulse_a"}, int'(pulse_a), 0);
        chk({tag, " R8 pulse_b"}, int'(pulse_b), 0);
        chk({tag, " R8 zero_evt"}, int'(zero_evt), 0);
        chk({tag, " R8 prd_evt"}, int'(prd_evt), 0);
        chk({tag, " R8 cfg_err"}, int'(cfg_err), 0);
    endtask

    task automatic release_and_sync(input string tag);
        int waited;
        rst_n = 1'b1;
        waited = 0;
        @(negedge clk); waited++;
        while (!zero_evt && waited < 10) begin @(negedge clk); waited++; end
        chk({tag, " R8 first zero strobe one clock after reset"}, waited, 1);
    endtask

    initial begin
        int pp, pw;
        repeat (3) @(negedge clk);
        check_reset_outputs("reset");
        release_and_sync("startup");

        // Vector table: each triangle checks the previous row and writes the next (R5, R9).
        pp = RP; pw = RW;
        for (int i = 0; i < NV; i++) begin
            measure(1'b1, VP[i], VW[i]);
            expect_tri($sformatf("vec%0d R5 R9", i), pp, pw);
            pp = VP[i]; pw = VW[i];
        end
        measure(1'b0, 0, 0);
        expect_tri("vec last", pp, pw);

        // R6: width write sampled on the zero edge is deferred one triangle.
        repeat (2 * pp - 1) @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = CW'(2);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6 zero strobe where predicted", int'(zero_evt), 1);
        measure(1'b0, 0, 0);
        expect_tri("R6 old width kept", pp, pw);
        measure(1'b0, 0, 0);
        expect_tri("R6 new width one triangle later", pp, 2);
        pw = 2;

        // R7: refused configurations, sticky error, recovery.
        chk("R7 no error yet", int'(cfg_err), 0);
        measure(1'b1, 6, 6);
        expect_tri("R7 before peak=width", pp, pw);
        measure(1'b1, 10, 0);
        expect_held("R7 peak equals width", pp);
        measure(1'b1, 10, 2);
        expect_held("R7 zero width", pp);
        measure(1'b0, 0, 0);
        expect_tri("R7 recovery", 10, 2);
        chk("R7 error stays set", int'(cfg_err), 1);

        // R8: reset mid-run restores defaults and clears the flag.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_reset_outputs("mid-run reset");
        release_and_sync("after reset");
        measure(1'b0, 0, 0);
        expect_tri("R8 defaults", RP, RW);
        chk("R8 error cleared", int'(cfg_err), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8ns * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule